// File: doc/BRIEF.md
# Programmable Clock Divider Channel with Phase Delay

This block is a single synchronous divider channel. It counts edges of its input clock and produces a divided output level. The output stays high for a programmed number of cycles and then low for a programmed number of cycles. The high count `hi_cnt_i` and the low count `lo_cnt_i` are separate fields, so the duty cycle can be set independently of the ratio. After a synchronization pulse, the first rising edge of the output can be pushed back by a programmed number of input cycles. This lets several channels fed from the same clock be skewed against each other in whole input periods.

All settings are captured from the inputs only while `sync_i` is high. The running output therefore never sees a half-applied change. The delay code is five bits wide: a 4-bit offset `ofs_i` plus an extended-delay bit `ext_i`. When the extended bit is set, the delay also counts through one full low phase. A bypass setting, also captured at sync, passes the input clock straight to the output so that it keeps the input duty cycle.

Top module: `clk_div_channel`

## Requirements
- R1: After reset, with no sync pulse applied, `div_clk_o` stays 0.
- R2: In every cycle that follows a rising clock edge at which `sync_i` was 1, `div_clk_o` is 0.
- R3: Once running, `div_clk_o` stays high for exactly `hi_cnt_i`+1 input cycles in each period.
- R4: Once running, `div_clk_o` stays low for exactly `lo_cnt_i`+1 input cycles, so the period is `hi_cnt_i`+`lo_cnt_i`+2 input cycles.
- R5: With `ext_i`=0, the output first goes high `ofs_i` cycles after the first clock edge with `sync_i` low. Delay 0 means the output is high right after that edge.
- R6: With `ext_i`=1, that first-edge delay is `ofs_i`+`lo_cnt_i`+1 cycles.
- R7: Changes to `hi_cnt_i`, `lo_cnt_i`, `ofs_i`, `ext_i` and `bypass_i` while `sync_i` is 0 have no effect on the output.
- R8: When `bypass_i` was 1 at the last sync, `div_clk_o` equals the input clock: high in the high half of the clock period and low in the low half.
- R9: With `lo_cnt_i` equal to `hi_cnt_i`, the high and low times are equal, giving a 50% output for the resulting even ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Sync: holds the output low, captures settings, restarts on release |
| bypass_i | input | 1 | Pass the input clock through unchanged |
| hi_cnt_i | input | 4 | High time minus one, in input cycles |
| lo_cnt_i | input | 4 | Low time minus one, in input cycles |
| ofs_i | input | 4 | Phase offset in input cycles |
| ext_i | input | 1 | Extended delay: adds low time to the offset |
| div_clk_o | output | 1 | Divided output |

## Verification
The ratio fields are swept over all 256 high/low pairs with zero offset. Because first-edge position, high run, low run and period are measured separately, a swap of the two fields or an off-by-one in either one stands apart. Phase codes are tried on both sides of the extended bit and with different low counts, which separates a plain offset from one that has wrongly absorbed, or failed to absorb, the low time. A mid-run rewrite of every setting without sync shows whether the settings are captured only at sync. A bypass run sampled in both clock halves separates a true pass-through from a divide-by-two.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_HIGH  = 2'd2,
    ST_LOW   = 2'd3
  } div_state_t;
endpackage

// File: rtl/clk_div_shadow.sv
module clk_div_shadow #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             byp_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             byp_o,
  output logic [CNT_W-1:0] hi_o,
  output logic [CNT_W-1:0] lo_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      byp_o <= 1'b0;
      hi_o  <= '0;
      lo_o  <= '0;
    end else if (load_i) begin
      byp_o <= byp_i;
      hi_o  <= hi_i;
      lo_o  <= lo_i;
    end
  end

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(hi_o) && $stable(lo_o) && $stable(byp_o)));
endmodule

// File: rtl/clk_div_delay.sv
module clk_div_delay #(
  parameter int CNT_W = 4,
  parameter int DLY_W = CNT_W + 2
) (
  input  logic             ext_i,
  input  logic [CNT_W-1:0] ofs_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic [DLY_W-1:0] dly_o
);
  always_comb begin
    if (ext_i)
      dly_o = DLY_W'(ofs_i) + DLY_W'(lo_i) + DLY_W'(1);
    else
      dly_o = DLY_W'(ofs_i);
  end
endmodule

// File: rtl/clk_div_core.sv
module clk_div_core
  import clk_div_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DLY_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             div_o
);
  div_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DLY_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wait_q  <= '0;
      div_o   <= 1'b0;
    end else if (sync_i) begin
      state_q <= ST_DELAY;
      cnt_q   <= '0;
      wait_q  <= dly_i;
      div_o   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          div_o <= 1'b0;
        end
        ST_DELAY: begin
          if (wait_q == '0) begin
            state_q <= ST_HIGH;
            div_o   <= 1'b1;
            cnt_q   <= '0;
          end else begin
            wait_q <= wait_q - DLY_W'(1);
          end
        end
        ST_HIGH: begin
          if (cnt_q == hi_i) begin
            state_q <= ST_LOW;
            div_o   <= 1'b0;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_LOW: begin
          if (cnt_q == lo_i) begin
            state_q <= ST_HIGH;
            div_o   <= 1'b1;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  sync_low_chk: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> !div_o);
  // R3
  high_len_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HIGH) |-> (cnt_q <= hi_i));
  // R4
  low_len_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOW) |-> (cnt_q <= lo_i));
  // R5
  delay_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DELAY) |-> !div_o);
  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !sync_i) |=> !div_o);
endmodule

// File: rtl/clk_div_channel.sv
module clk_div_channel #(
  parameter int CNT_W     = 4,
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  input  logic             bypass_i,
  input  logic [CNT_W-1:0] hi_cnt_i,
  input  logic [CNT_W-1:0] lo_cnt_i,
  input  logic [CNT_W-1:0] ofs_i,
  input  logic             ext_i,
  output logic             div_clk_o
);
  localparam int DLY_W = CNT_W + 2;

  logic             byp_q;
  logic [CNT_W-1:0] hi_q;
  logic [CNT_W-1:0] lo_q;
  logic [DLY_W-1:0] dly;
  logic             div_q;

  clk_div_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk    (clk),
    .rst    (rst),
    .load_i (sync_i),
    .byp_i  (bypass_i),
    .hi_i   (hi_cnt_i),
    .lo_i   (lo_cnt_i),
    .byp_o  (byp_q),
    .hi_o   (hi_q),
    .lo_o   (lo_q)
  );

  clk_div_delay #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_delay (
    .ext_i (ext_i),
    .ofs_i (ofs_i),
    .lo_i  (lo_cnt_i),
    .dly_o (dly)
  );

  clk_div_core #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .sync_i (sync_i),
    .dly_i  (dly),
    .hi_i   (hi_q),
    .lo_i   (lo_q),
    .div_o  (div_q)
  );

  generate
    if (BYPASS_EN) begin : g_byp
      assign div_clk_o = byp_q ? clk : div_q;
    end else begin : g_nobyp
      logic unused_byp;
      assign unused_byp = byp_q;
      assign div_clk_o  = div_q;
    end
  endgenerate
endmodule

// File: tb/tb_clk_div_channel.sv
module tb_clk_div_channel;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       sync_i;
  logic       bypass_i;
  logic [3:0] hi_cnt_i;
  logic [3:0] lo_cnt_i;
  logic [3:0] ofs_i;
  logic       ext_i;
  logic       div_clk_o;

  int checks   = 0;
  int failures = 0;

  clk_div_channel dut (
    .clk(clk), .rst(rst), .sync_i(sync_i), .bypass_i(bypass_i),
    .hi_cnt_i(hi_cnt_i), .lo_cnt_i(lo_cnt_i), .ofs_i(ofs_i),
    .ext_i(ext_i), .div_clk_o(div_clk_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_sync(input int n, input int m, input int po, input bit sh, input bit byp);
    @(negedge clk);
    hi_cnt_i = 4'(n); lo_cnt_i = 4'(m); ofs_i = 4'(po); ext_i = sh; bypass_i = byp;
    sync_i = 1'b1;
    repeat (2) @(negedge clk);
    sync_i = 1'b0;
  endtask

  // Samples at falling edges from now on; measures first rise, high run, low run, period.
  task automatic measure(input int exp_d, input int n, input int m, input string tag);
    int first = -1, hlen = 0, llen = 0, second = -1, ph = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (ph == 0 && div_clk_o) begin first = i; hlen = 1; ph = 1; end
      else if (ph == 1) begin
        if (div_clk_o) hlen++; else begin llen = 1; ph = 2; end
      end else if (ph == 2) begin
        if (!div_clk_o) llen++; else begin second = i; break; end
      end
    end
    if (exp_d >= 0) check({tag, " first-edge delay"}, first, exp_d);
    check({"R3 high time ", tag}, hlen, n + 1);
    check({"R4 low time ", tag}, llen, m + 1);
    check({"R4 period ", tag}, second - first, n + m + 2);
  endtask

  task automatic t_reset;
    rst = 1'b1; sync_i = 1'b0; bypass_i = 1'b0;
    hi_cnt_i = 4'd1; lo_cnt_i = 4'd1; ofs_i = 4'd0; ext_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R1 idle after reset", int'(div_clk_o), 0);
    end
  endtask

  task automatic t_sweep;
    for (int n = 0; n < 16; n++)
      for (int m = 0; m < 16; m++) begin
        do_sync(n, m, 0, 1'b0, 1'b0);
        measure(0, n, m, "R5 sweep");
      end
  endtask

  task automatic t_phase;
    do_sync(3, 4, 5, 1'b0, 1'b0);  measure(5, 3, 4, "R5 ofs5");
    do_sync(3, 4, 15, 1'b0, 1'b0); measure(15, 3, 4, "R5 ofs15");
    do_sync(3, 4, 0, 1'b1, 1'b0);  measure(5, 3, 4, "R6 ext ofs0");
    do_sync(3, 4, 15, 1'b1, 1'b0); measure(20, 3, 4, "R6 ext ofs15");
    do_sync(2, 0, 7, 1'b1, 1'b0);  measure(8, 2, 0, "R6 ext m0");
    do_sync(15, 15, 15, 1'b1, 1'b0); measure(31, 15, 15, "R6 ext max");
  endtask

  task automatic t_sync_hold;
    do_sync(1, 1, 0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    sync_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 low during sync", int'(div_clk_o), 0);
    end
    sync_i = 1'b0;
  endtask

  task automatic t_shadow;
    do_sync(2, 3, 0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    hi_cnt_i = 4'd9; lo_cnt_i = 4'd11; ofs_i = 4'd6; ext_i = 1'b1; bypass_i = 1'b1;
    while (div_clk_o) @(negedge clk);
    measure(-1, 2, 3, "R7 ignored writes");
    @(posedge clk); #(CLK_P/4);
    checks++;
    if (div_clk_o !== 1'b0 && div_clk_o !== 1'b1) begin
      failures++; $display("FAIL R7 output unknown actual=%b expected=0/1", div_clk_o);
    end
  endtask

  task automatic t_bypass;
    do_sync(4, 4, 3, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #(CLK_P/4);
      check("R8 bypass high half", int'(div_clk_o), 1);
      @(negedge clk); #(CLK_P/4);
      check("R8 bypass low half", int'(div_clk_o), 0);
    end
  endtask

  task automatic t_even;
    int hl, ll;
    for (int k = 0; k < 16; k += 5) begin
      do_sync(k, k, 0, 1'b0, 1'b0);
      hl = 0; ll = 0;
      @(negedge clk);
      while (div_clk_o) begin hl++; @(negedge clk); end
      while (!div_clk_o) begin ll++; @(negedge clk); end
      check("R9 equal high and low", hl, ll);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset;
    t_sync_hold;
    t_sweep;
    t_phase;
    t_shadow;
    t_bypass;
    t_even;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule